// File: doc/BRIEF.md
# Transmit Forward and Refill Controller

This block is the per-channel control logic that sits beside one section of a shared transmit buffer. It does not hold any data. It watches the section's fill level and the number of frame-end markers held in the section, and it makes two decisions. The first decision is when buffered words may be handed to the serial engine. The second is when the DMA engine should fetch more words into the section.

Forwarding starts for one of two reasons: a whole frame is present, or the fill level has risen above a programmable forward watermark. Once forwarding has started, it runs to the end of the current frame. At each frame boundary the two start conditions are checked again. Refill works with hysteresis. Fetching runs until the section is full and then stops. It resumes only when the fill level falls below a programmable refill watermark. Both watermarks are counted in 32-bit words, and each is limited to the configured section size.

Top module: `tfc_tx_ctrl`

## Requirements
- R1: While forwarding is idle, a nonzero frame-end count in one cycle makes `fwd_en_o` high in the next cycle, whatever the fill level.
- R2: While idle with a zero frame-end count, `fwd_en_o` rises in the next cycle only if the fill level is strictly greater than the effective forward watermark. A fill level equal to the watermark does not start forwarding.
- R3: While `fwd_en_o` is high, it stays high until `frame_done_i` is seen, whatever the fill level and frame-end count.
- R4: A cycle with `fwd_en_o` and `frame_done_i` both high is followed by exactly one cycle with `fwd_en_o` low. In that low cycle the R1 and R2 conditions are checked again, so a partial next frame below the watermark keeps forwarding stopped.
- R5: A forward watermark above `sec_size_i` acts as `sec_size_i`. A full section therefore does not start forwarding on level alone.
- R6: With a nonzero section size and a fill level of 0, `dma_req_o` is high in the same cycle.
- R7: `dma_req_o` is low in any cycle where the fill level is at or above `sec_size_i`.
- R8: After the section has been full, `dma_req_o` stays low while the fill level is at or above the effective refill watermark. It rises in the same cycle the fill level drops below that watermark.
- R9: Once `dma_req_o` is high, it stays high on following cycles until the section is full, even when the fill level is above the refill watermark.
- R10: A refill watermark above `sec_size_i` acts as `sec_size_i`. Fetching then resumes as soon as the section is no longer full.
- R11: During reset, `fwd_en_o` is low and the fetch state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_lvl_i | input | LVL_W | Words held in the section |
| fe_cnt_i | input | FE_W | Frame-end markers held in the section |
| fwd_thr_i | input | LVL_W | Forward watermark in words |
| rfl_thr_i | input | LVL_W | Refill watermark in words |
| sec_size_i | input | LVL_W | Configured section size in words |
| frame_done_i | input | 1 | Pulse: the last word of a frame has gone to the serial engine |
| fwd_en_o | output | 1 | Forwarding to the serial engine allowed |
| dma_req_o | output | 1 | DMA fetch request |

## Verification
The assertions assume that the section size and both watermarks stay fixed while the block runs. They also assume that the fill level never exceeds the section size and that `frame_done_i` is pulsed only while forwarding is enabled. The stimulus changes the watermark configuration only between scenarios, with inputs held steady around each change. It keeps every fill level within the section and raises the frame-done pulse only in cycles where the reference model has forwarding active.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef enum logic {
    FWD_IDLE   = 1'b0,
    FWD_ACTIVE = 1'b1
  } fwd_state_e;
endpackage

// File: rtl/tfc_thr_clamp.sv
module tfc_thr_clamp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] thr_i,
  input  logic [W-1:0] size_i,
  output logic [W-1:0] thr_o
);
  assign thr_o = (thr_i > size_i) ? size_i : thr_i;
endmodule

// File: rtl/tfc_fwd_ctrl.sv
module tfc_fwd_ctrl
  import tfc_pkg::*;
#(
  parameter int unsigned LVL_W = 8,
  parameter int unsigned FE_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fill_lvl_i,
  input  logic [FE_W-1:0]  fe_cnt_i,
  input  logic [LVL_W-1:0] thr_eff_i,
  input  logic             frame_done_i,
  output logic             fwd_en_o
);
  fwd_state_e state_q, state_d;
  logic       start_ok;

  // either a whole frame or a watermark crossing
  assign start_ok = (fe_cnt_i != '0) || (fill_lvl_i > thr_eff_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FWD_IDLE:   if (start_ok)     state_d = FWD_ACTIVE;
      FWD_ACTIVE: if (frame_done_i) state_d = FWD_IDLE;  // re-check in idle
      default:                      state_d = FWD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FWD_IDLE;
    else         state_q <= state_d;
  end

  assign fwd_en_o = (state_q == FWD_ACTIVE);
endmodule

// File: rtl/tfc_refill_ctrl.sv
module tfc_refill_ctrl #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fill_lvl_i,
  input  logic [LVL_W-1:0] thr_eff_i,
  input  logic [LVL_W-1:0] sec_size_i,
  output logic             dma_req_o
);
  logic fetch_q;
  logic full, low;

  assign full = (fill_lvl_i >= sec_size_i);
  assign low  = (fill_lvl_i == '0) || (fill_lvl_i < thr_eff_i);

  // drops in the cycle full is seen
  assign dma_req_o = !full && (fetch_q || low);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fetch_q <= 1'b0;
    else         fetch_q <= dma_req_o;
  end
endmodule

// File: rtl/tfc_tx_ctrl.sv
module tfc_tx_ctrl #(
  parameter  int unsigned DEPTH = 128,
  parameter  int unsigned FE_W  = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fill_lvl_i,
  input  logic [FE_W-1:0]  fe_cnt_i,
  input  logic [LVL_W-1:0] fwd_thr_i,
  input  logic [LVL_W-1:0] rfl_thr_i,
  input  logic [LVL_W-1:0] sec_size_i,
  input  logic             frame_done_i,
  output logic             fwd_en_o,
  output logic             dma_req_o
);
  localparam int unsigned N_THR = 2;

  logic [LVL_W-1:0] thr_raw [N_THR];
  logic [LVL_W-1:0] thr_eff [N_THR];

  assign thr_raw[0] = fwd_thr_i;
  assign thr_raw[1] = rfl_thr_i;

  for (genvar g = 0; g < N_THR; g++) begin : g_clamp
    tfc_thr_clamp #(.W(LVL_W)) u_clamp (
      .thr_i  (thr_raw[g]),
      .size_i (sec_size_i),
      .thr_o  (thr_eff[g])
    );
  end

  tfc_fwd_ctrl #(.LVL_W(LVL_W), .FE_W(FE_W)) u_fwd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_lvl_i   (fill_lvl_i),
    .fe_cnt_i     (fe_cnt_i),
    .thr_eff_i    (thr_eff[0]),
    .frame_done_i (frame_done_i),
    .fwd_en_o     (fwd_en_o)
  );

  tfc_refill_ctrl #(.LVL_W(LVL_W)) u_rfl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_lvl_i (fill_lvl_i),
    .thr_eff_i  (thr_eff[1]),
    .sec_size_i (sec_size_i),
    .dma_req_o  (dma_req_o)
  );
endmodule

// File: rtl/tfc_tx_ctrl_chk.sv
module tfc_tx_ctrl_chk #(
  parameter int unsigned LVL_W = 8,
  parameter int unsigned FE_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] fill_lvl_i,
  input logic [FE_W-1:0]  fe_cnt_i,
  input logic [LVL_W-1:0] fwd_thr_i,
  input logic [LVL_W-1:0] sec_size_i,
  input logic             frame_done_i,
  input logic             fwd_en_o,
  input logic             dma_req_o
);
  logic [LVL_W-1:0] fwd_lim;
  assign fwd_lim = (fwd_thr_i > sec_size_i) ? sec_size_i : fwd_thr_i;

  AST_RESET_FWD_LOW: assert property (@(posedge clk_i) !rst_ni |-> !fwd_en_o); // R11

  AST_FE_STARTS_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwd_en_o && fe_cnt_i != '0) |=> fwd_en_o); // R1

  AST_NO_EARLY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwd_en_o && fe_cnt_i == '0 && fill_lvl_i <= fwd_lim) |=> !fwd_en_o); // R2

  AST_FWD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_en_o && !frame_done_i) |=> fwd_en_o); // R3

  AST_FWD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_en_o && frame_done_i) |=> !fwd_en_o); // R4

  AST_EMPTY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_lvl_i == '0 && sec_size_i != '0) |-> dma_req_o); // R6

  AST_FULL_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_lvl_i >= sec_size_i) |-> !dma_req_o); // R7

  AST_FETCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |=> (dma_req_o || fill_lvl_i >= sec_size_i)); // R9
endmodule

bind tfc_tx_ctrl tfc_tx_ctrl_chk #(.LVL_W(LVL_W), .FE_W(FE_W)) i_tfc_tx_ctrl_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fill_lvl_i   (fill_lvl_i),
  .fe_cnt_i     (fe_cnt_i),
  .fwd_thr_i    (fwd_thr_i),
  .sec_size_i   (sec_size_i),
  .frame_done_i (frame_done_i),
  .fwd_en_o     (fwd_en_o),
  .dma_req_o    (dma_req_o)
);

// File: tb/test_tfc_tx_ctrl.sv
`timescale 1ns/1ps
module test_tfc_tx_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] fill = '0;
  logic [3:0] fe = '0;
  logic [7:0] fwd_thr = 8'd20;
  logic [7:0] rfl_thr = 8'd10;
  logic [7:0] size = 8'd40;
  logic       done = 1'b0;
  logic       fwd_en, dma_req;

  int checks = 0;
  int fails = 0;
  int m_fwd = 0;
  int m_fetch = 0;

  always #4 clk = ~clk;

  tfc_tx_ctrl i_tfc_tx_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .fill_lvl_i(fill), .fe_cnt_i(fe),
    .fwd_thr_i(fwd_thr), .rfl_thr_i(rfl_thr), .sec_size_i(size),
    .frame_done_i(done), .fwd_en_o(fwd_en), .dma_req_o(dma_req)
  );

  function automatic int lim(int t, int s);
    return (t > s) ? s : t;
  endfunction

  function automatic int model_req();
    int f = int'(fill);
    int s = int'(size);
    if (f >= s) return 0;
    if (m_fetch != 0 || f == 0 || f < lim(int'(rfl_thr), s)) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_fwd <= 0;
      m_fetch <= 0;
    end else begin
      m_fetch <= model_req();
      if (m_fwd == 0) begin
        if (fe != 0 || int'(fill) > lim(int'(fwd_thr), int'(size))) m_fwd <= 1;
      end else if (done) begin
        m_fwd <= 0;
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input int f, input int e, input bit d, input string tag);
    @(negedge clk);
    fill = f[7:0];
    fe = e[3:0];
    done = d;
    #1;
    check(tag, "fwd_en", int'(fwd_en), m_fwd);
    check(tag, "dma_req", int'(dma_req), model_req());
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    fill = 8'd5;
    fe = 4'd1;
    repeat (3) @(negedge clk);
    check("R11", "fwd_en in reset", int'(fwd_en), 0);
    fill = 8'd0;
    fe = 4'd0;
    @(negedge clk);
    rst_ni = 1'b1;
    // R6: empty section requests, R9 holds while filling above refill mark
    step(0, 0, 0, "R6");
    check("R6", "req when empty", int'(dma_req), 1);
    for (int i = 1; i < 40; i++) step(i, 0, 0, (i > 20) ? "R2" : "R9");
    check("R9", "req held at 39", int'(dma_req), 1);
    check("R2", "fwd after level above mark", int'(fwd_en), 1);
    // R7: full stops fetch in same cycle
    step(40, 0, 0, "R7");
    check("R7", "req at full", int'(dma_req), 0);
    // R3: level drops, forwarding holds with no frame done
    for (int i = 39; i >= 10; i--) step(i, 0, 0, "R8");
    check("R8", "no req at refill mark", int'(dma_req), 0);
    step(9, 0, 0, "R8");
    check("R8", "req below refill mark", int'(dma_req), 1);
    step(5, 0, 0, "R3");
    step(3, 0, 0, "R3");
    check("R3", "fwd held", int'(fwd_en), 1);
    // R4: frame done with partial frame below mark -> stop
    step(5, 0, 1, "R4");
    step(5, 0, 0, "R4");
    check("R4", "gap after frame", int'(fwd_en), 0);
    repeat (3) step(6, 0, 0, "R4");
    check("R4", "partial frame waits", int'(fwd_en), 0);
    // R2: equal to mark does not start
    step(20, 0, 0, "R2");
    step(20, 0, 0, "R2");
    check("R2", "no start at mark", int'(fwd_en), 0);
    // R1: frame end starts below mark
    step(3, 1, 0, "R1");
    step(3, 1, 0, "R1");
    check("R1", "start on frame end", int'(fwd_en), 1);
    // R4: done with another frame stored -> one-cycle gap then restart
    step(3, 1, 1, "R4");
    step(3, 1, 0, "R4");
    check("R4", "gap cycle", int'(fwd_en), 0);
    step(3, 1, 0, "R4");
    check("R4", "restart after gap", int'(fwd_en), 1);
    step(3, 0, 1, "R4");
    step(0, 0, 0, "R4");
    // R5: forward mark beyond size
    fwd_thr = 8'd200;
    step(40, 0, 0, "R5");
    repeat (3) step(40, 0, 0, "R5");
    check("R5", "no level start when full", int'(fwd_en), 0);
    check("R7", "no req at full", int'(dma_req), 0);
    // R10: refill mark beyond size resumes at first free word
    rfl_thr = 8'd200;
    step(40, 0, 0, "R10");
    step(39, 0, 0, "R10");
    check("R10", "req one below full", int'(dma_req), 1);
    step(39, 0, 0, "R10");
    step(40, 0, 0, "R10");
    check("R7", "req drop at full", int'(dma_req), 0);
    fwd_thr = 8'd20;
    rfl_thr = 8'd10;
    step(40, 0, 0, "R2");
    step(38, 2, 0, "R1");
    step(38, 2, 0, "R1");
    check("R1", "start with frames", int'(fwd_en), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule